// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run in parallel on every lookup. The first keeps a separate outcome history for each branch address, and that history selects a saturating counter. The second uses one shared history of the most recent branch outcomes, and that history selects its own counter. A third table of 2-bit selector counters, indexed by the shared history, decides which of the two component predictions becomes the final answer.

A lookup is combinational. The fetch stage drives a PC and reads back the final prediction, both component predictions and both history values in the same cycle. It keeps these until the branch resolves. At resolution it presents the PC, the real outcome and the saved values for one cycle with the update strobe high. The block then trains all three counter tables and shifts the outcome into both histories. History is not recovered after a misprediction, and no target address is produced.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every local counter is 3 (3-bit, weakly not-taken) and every global counter is 1 (2-bit, weakly not-taken). Every selector counter is 1, which is weakly toward local. All histories are zero, so every lookup returns 0 on every prediction and history output.
- R2: The per-branch history entry is selected by PC bits [11:2]. PCs that differ only outside those bits share an entry. On an update the outcome shifts into that entry at bit 0, and the older bits move up by one.
- R3: The local prediction is bit 2 (the MSB) of the 3-bit counter selected by the 10-bit per-branch history.
- R4: The shared history is a 12-bit shift register. On every update the outcome enters at bit 0, where 1 means taken and 0 means not taken.
- R5: The global prediction is bit 1 (the MSB) of the 2-bit counter selected by the 12-bit shared history.
- R6: The selector counter is indexed by the shared history. When its MSB is 1 the final prediction is the global one, and when it is 0 the final prediction is the local one. The `predUseGlobal` output shows this MSB.
- R7: On an update, the local counter at the saved per-branch history and the global counter at the saved shared history both move by one toward the outcome. Both saturate: the local counter stays within 0..7 and the global counter within 0..3.
- R8: The selector counter at the saved shared history changes only when the saved local and global predictions differ. It then moves one step toward global if the global prediction matched the outcome, and one step toward local otherwise, saturating within 0..3.
- R9: Lookups read the current table state without a register. The effect of an update is visible to a lookup in the cycle after the update edge.
- R10: While `updValid` is low, neither the tables nor the histories change, whatever the other update inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupPc | input | 32 | PC of the branch being fetched |
| predTaken | output | 1 | Final direction prediction |
| predLocal | output | 1 | Local component prediction |
| predGlobal | output | 1 | Global component prediction |
| predUseGlobal | output | 1 | Selector MSB: 1 means the global prediction was chosen |
| predLocalHist | output | 10 | Per-branch history of the looked-up PC |
| predGlobalHist | output | 12 | Current shared history |
| updValid | input | 1 | Resolution update strobe |
| updPc | input | 32 | PC of the resolved branch |
| updTaken | input | 1 | Actual outcome |
| updLocalPred | input | 1 | Saved local prediction |
| updGlobalPred | input | 1 | Saved global prediction |
| updLocalHist | input | 10 | Saved per-branch history |
| updGlobalHist | input | 12 | Saved shared history |

## Verification
Every lookup result is due in the same cycle the PC is driven, because the read path has no register. The bench drives `lookupPc` just after a falling edge and samples all six outputs 1 ns later, well before the next rising edge. An update is committed at the rising edge while `updValid` is high, so its effect is due one cycle later. The bench changes its reference tables only after that edge and checks the next lookup against them. For R8 and R10, the bench also builds updates whose saved history equals the shared history that will follow them. The selector state then shows up directly on `predUseGlobal` in the next cycle.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Strobes from control to datapath for one resolution update
  typedef struct packed {
    logic trainEn;       // train component counters and shift histories
    logic chooseEn;      // selector counter is allowed to move
    logic chooseGlobal;  // direction of selector move: 1 toward global
  } tpStrobes_t;
endpackage

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updLocalPred,
  input  logic       updGlobalPred,
  output tpStrobes_t strobes
);
  always_comb begin
    strobes.trainEn      = updValid;
    strobes.chooseEn     = updValid && (updLocalPred != updGlobalPred);
    strobes.chooseGlobal = (updGlobalPred == updTaken);
  end
endmodule

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int LIDX_W = 10,
  parameter int LH_W   = 10,
  parameter int LC_W   = 3,
  parameter int GH_W   = 12,
  parameter int GC_W   = 2,
  parameter int CC_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tpStrobes_t        strobes,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [PC_W-1:0]   updPc,
  input  logic              updTaken,
  input  logic [LH_W-1:0]   updLocalHist,
  input  logic [GH_W-1:0]   updGlobalHist,
  output logic              predTaken,
  output logic              predLocal,
  output logic              predGlobal,
  output logic              predUseGlobal,
  output logic [LH_W-1:0]   predLocalHist,
  output logic [GH_W-1:0]   predGlobalHist
);
  localparam int LHT_N  = 1 << LIDX_W;
  localparam int LCT_N  = 1 << LH_W;
  localparam int GCT_N  = 1 << GH_W;
  localparam logic [LC_W-1:0] LC_MAX  = '1;
  localparam logic [GC_W-1:0] GC_MAX  = '1;
  localparam logic [CC_W-1:0] CC_MAX  = '1;
  localparam logic [LC_W-1:0] LC_INIT = LC_MAX >> 1;
  localparam logic [GC_W-1:0] GC_INIT = GC_MAX >> 1;
  localparam logic [CC_W-1:0] CC_INIT = CC_MAX >> 1;

  logic [LH_W-1:0] localHistTbl [LHT_N];
  logic [LC_W-1:0] localCtrTbl  [LCT_N];
  logic [GC_W-1:0] globalCtrTbl [GCT_N];
  logic [CC_W-1:0] chooserTbl   [GCT_N];
  logic [GH_W-1:0] globalHist;

  logic [LIDX_W-1:0] lookIdx, updIdx;
  logic [LC_W-1:0]   localCtrNext;
  logic [GC_W-1:0]   globalCtrNext;
  logic [CC_W-1:0]   chooserNext;

  assign lookIdx = lookupPc[PC_LSB +: LIDX_W];
  assign updIdx  = updPc[PC_LSB +: LIDX_W];

  // Lookup path: no register between tables and outputs
  always_comb begin
    predLocalHist  = localHistTbl[lookIdx];
    predGlobalHist = globalHist;
    predLocal      = localCtrTbl[predLocalHist][LC_W-1];
    predGlobal     = globalCtrTbl[globalHist][GC_W-1];
    predUseGlobal  = chooserTbl[globalHist][CC_W-1];
    predTaken      = predUseGlobal ? predGlobal : predLocal;
  end

  // Saturating next values for the update path
  always_comb begin
    localCtrNext  = localCtrTbl[updLocalHist];
    globalCtrNext = globalCtrTbl[updGlobalHist];
    chooserNext   = chooserTbl[updGlobalHist];
    if (updTaken) begin
      if (localCtrNext != LC_MAX)  localCtrNext  = localCtrNext + 1'b1;
      if (globalCtrNext != GC_MAX) globalCtrNext = globalCtrNext + 1'b1;
    end else begin
      if (localCtrNext != '0)  localCtrNext  = localCtrNext - 1'b1;
      if (globalCtrNext != '0) globalCtrNext = globalCtrNext - 1'b1;
    end
    if (strobes.chooseGlobal) begin
      if (chooserNext != CC_MAX) chooserNext = chooserNext + 1'b1;
    end else begin
      if (chooserNext != '0) chooserNext = chooserNext - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalHist <= '0;
      for (int i = 0; i < LHT_N; i++) localHistTbl[i] <= '0;
      for (int i = 0; i < LCT_N; i++) localCtrTbl[i]  <= LC_INIT;
      for (int i = 0; i < GCT_N; i++) begin
        globalCtrTbl[i] <= GC_INIT;
        chooserTbl[i]   <= CC_INIT;
      end
    end else if (strobes.trainEn) begin
      globalHist                  <= {globalHist[GH_W-2:0], updTaken};
      localHistTbl[updIdx]        <= {localHistTbl[updIdx][LH_W-2:0], updTaken};
      localCtrTbl[updLocalHist]   <= localCtrNext;
      globalCtrTbl[updGlobalHist] <= globalCtrNext;
      if (strobes.chooseEn) chooserTbl[updGlobalHist] <= chooserNext;
    end
  end

  // R10
  ghist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.trainEn |=> $stable(globalHist));

  // R4
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trainEn |=> globalHist[0] == $past(updTaken));

  // R7
  lctr_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.trainEn && updTaken && localCtrTbl[updLocalHist] == LC_MAX)
      |=> localCtrTbl[$past(updLocalHist)] == LC_MAX);

  // R8
  chooser_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.trainEn && !strobes.chooseEn)
      |=> chooserTbl[$past(updGlobalHist)] == $past(chooserTbl[updGlobalHist]));
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int LIDX_W = 10,
  parameter int LH_W   = 10,
  parameter int LC_W   = 3,
  parameter int GH_W   = 12,
  parameter int GC_W   = 2,
  parameter int CC_W   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  output logic            predLocal,
  output logic            predGlobal,
  output logic            predUseGlobal,
  output logic [LH_W-1:0] predLocalHist,
  output logic [GH_W-1:0] predGlobalHist,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updLocalPred,
  input  logic            updGlobalPred,
  input  logic [LH_W-1:0] updLocalHist,
  input  logic [GH_W-1:0] updGlobalHist
);
  tpStrobes_t strobes;

  tp_ctrl u_ctrl (
    .updValid      (updValid),
    .updTaken      (updTaken),
    .updLocalPred  (updLocalPred),
    .updGlobalPred (updGlobalPred),
    .strobes       (strobes)
  );

  tp_datapath #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .LIDX_W(LIDX_W), .LH_W(LH_W),
    .LC_W(LC_W), .GH_W(GH_W), .GC_W(GC_W), .CC_W(CC_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .lookupPc       (lookupPc),
    .updPc          (updPc),
    .updTaken       (updTaken),
    .updLocalHist   (updLocalHist),
    .updGlobalHist  (updGlobalHist),
    .predTaken      (predTaken),
    .predLocal      (predLocal),
    .predGlobal     (predGlobal),
    .predUseGlobal  (predUseGlobal),
    .predLocalHist  (predLocalHist),
    .predGlobalHist (predGlobalHist)
  );
endmodule

// File: tb/tourney_predictor_tb.sv
module tourney_predictor_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] lookupPc = 0;
  logic        predTaken, predLocal, predGlobal, predUseGlobal;
  logic [9:0]  predLocalHist;
  logic [11:0] predGlobalHist;
  logic        updValid = 0;
  logic [31:0] updPc = 0;
  logic        updTaken = 0, updLocalPred = 0, updGlobalPred = 0;
  logic [9:0]  updLocalHist = 0;
  logic [11:0] updGlobalHist = 0;

  int checks = 0, fails = 0;

  // reference state built from the requirements
  int lhtM [1024];
  int lctM [1024];
  int gctM [4096];
  int cctM [4096];
  int ghistM;

  always #10 clk = ~clk;

  tourney_predictor u_dut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc),
    .predTaken(predTaken), .predLocal(predLocal), .predGlobal(predGlobal),
    .predUseGlobal(predUseGlobal), .predLocalHist(predLocalHist),
    .predGlobalHist(predGlobalHist), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken), .updLocalPred(updLocalPred), .updGlobalPred(updGlobalPred),
    .updLocalHist(updLocalHist), .updGlobalHist(updGlobalHist)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 1024; i++) begin lhtM[i] = 0; lctM[i] = 3; end
    for (int i = 0; i < 4096; i++) begin gctM[i] = 1; cctM[i] = 1; end
    ghistM = 0;
  endtask

  // lookup at pc, compare every output against the reference tables
  task automatic lookupChk(input logic [31:0] pc, input string tag,
                           output int lh, output int lp, output int gp);
    int ug, pt;
    @(negedge clk);
    lookupPc = pc;
    #1;
    lh = lhtM[pc[11:2]];
    lp = (lctM[lh] >= 4) ? 1 : 0;
    gp = (gctM[ghistM] >= 2) ? 1 : 0;
    ug = (cctM[ghistM] >= 2) ? 1 : 0;
    pt = ug ? gp : lp;
    chk({"R2 local hist ", tag}, predLocalHist, lh);
    chk({"R4 global hist ", tag}, predGlobalHist, ghistM);
    chk({"R3 local pred ", tag}, predLocal, lp);
    chk({"R5 global pred ", tag}, predGlobal, gp);
    chk({"R6 use global ", tag}, predUseGlobal, ug);
    chk({"R6 final pred ", tag}, predTaken, pt);
  endtask

  // one update with explicit saved values; reference follows R2/R4/R7/R8
  task automatic applyUpd(input logic [31:0] pc, input bit t, input bit lp,
                          input bit gp, input int lh, input int gh);
    updValid = 1; updPc = pc; updTaken = t; updLocalPred = lp;
    updGlobalPred = gp; updLocalHist = lh[9:0]; updGlobalHist = gh[11:0];
    @(posedge clk);
    #1;
    updValid = 0;
    lhtM[pc[11:2]] = ((lhtM[pc[11:2]] << 1) | int'(t)) & 32'h3FF;
    ghistM = ((ghistM << 1) | int'(t)) & 32'hFFF;
    if (t) begin
      if (lctM[lh] < 7) lctM[lh]++;
      if (gctM[gh] < 3) gctM[gh]++;
    end else begin
      if (lctM[lh] > 0) lctM[lh]--;
      if (gctM[gh] > 0) gctM[gh]--;
    end
    if (lp != gp) begin
      if (gp == t) begin if (cctM[gh] < 3) cctM[gh]++; end
      else if (cctM[gh] > 0) cctM[gh]--;
    end
  endtask

  task automatic branch(input logic [31:0] pc, input bit t, input string tag);
    int lh, lp, gp;
    lookupChk(pc, tag, lh, lp, gp);
    applyUpd(pc, t, lp[0], gp[0], lh, ghistM);
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    modelReset();
  endtask

  task automatic testReset();
    int lh, lp, gp;
    lookupChk(32'h0000_0000, "R1 reset a", lh, lp, gp);
    lookupChk(32'hFFFF_FFFC, "R1 reset b", lh, lp, gp);
    chk("R1 reset pred", predTaken, 0);
    chk("R1 reset chooser local", predUseGlobal, 0);
  endtask

  task automatic testLoop();
    for (int k = 0; k < 8; k++) begin
      branch(32'h0000_1000, 1, "R9 loop");
      branch(32'h0000_1000, 1, "R9 loop");
      branch(32'h0000_1000, 1, "R9 loop");
      branch(32'h0000_1000, 0, "R9 loop exit");
    end
  endtask

  task automatic testAlternate();
    for (int k = 0; k < 10; k++) branch(32'h0000_2040, k[0], "R3 alternate");
  endtask

  task automatic testSaturate();
    for (int k = 0; k < 14; k++) branch(32'h0000_3300, 1, "R7 sat up");
    for (int k = 0; k < 14; k++) branch(32'h0000_3300, 0, "R7 sat down");
  endtask

  task automatic testAlias();
    int lh, lp, gp;
    branch(32'h0000_0124, 1, "R2 alias");
    branch(32'h0000_0124, 1, "R2 alias");
    lookupChk(32'h0000_1124, "R2 alias partner", lh, lp, gp);
    chk("R2 aliased entry shared", predLocalHist, lhtM[9'h49]);
    lookupChk(32'h0000_0128, "R2 neighbour", lh, lp, gp);
  endtask

  task automatic testChooser();
    int lh, lp, gp, nxt;
    // global correct, local wrong, trained at the history that follows
    nxt = ((ghistM << 1) | 1) & 32'hFFF;
    applyUpd(32'h0000_0400, 1, 0, 1, 0, nxt);
    lookupChk(32'h0000_0400, "R8 toward global", lh, lp, gp);
    chk("R8 chooser moved to global", predUseGlobal, 1);
    // agreement leaves the selector alone
    nxt = ((ghistM << 1) | 0) & 32'hFFF;
    cctM[nxt] = cctM[nxt];
    applyUpd(32'h0000_0400, 0, 1, 1, 5, nxt);
    lookupChk(32'h0000_0400, "R8 agree hold", lh, lp, gp);
    // local correct, global wrong: pulls back toward local
    nxt = ((ghistM << 1) | 0) & 32'hFFF;
    applyUpd(32'h0000_0400, 0, 0, 1, 7, nxt);
    lookupChk(32'h0000_0400, "R8 toward local", lh, lp, gp);
  endtask

  task automatic testIdle();
    int lh, lp, gp, gh0;
    gh0 = ghistM;
    @(negedge clk);
    updPc = 32'h0000_1000; updTaken = 1; updLocalPred = 0; updGlobalPred = 1;
    updLocalHist = 10'h3FF; updGlobalHist = gh0[11:0];
    repeat (4) @(posedge clk);
    lookupChk(32'h0000_1000, "R10 idle", lh, lp, gp);
    chk("R10 global hist unchanged", predGlobalHist, gh0);
    chk("R10 chooser unchanged", predUseGlobal, (cctM[gh0] >= 2) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    modelReset();
    doReset();
    testReset();
    testLoop();
    testAlternate();
    testSaturate();
    testAlias();
    testChooser();
    testIdle();
    for (int k = 0; k < 40; k++)
      branch(32'h0000_5000 + 32'(k % 5) * 4, ((k * 7) % 3) != 0, "R5 mixed");
    doReset();
    testReset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule